// File: doc/BRIEF.md
# USB PHY Power Sequencer

This block brings four USB PHY instances up and down in hardware: a device PHY, a host PHY and two chip-to-chip high-speed ports (HSIC). A requester hands it one instance number and an on/off flag at a time. For each request the block walks a fixed sequence and drives register images that feed the PHY macro: a power-control word with suspend, power and sleep bits for each instance, a reset-control word, three isolation enables, a reference-frequency select code and a device/host mode bit.

A power-up first selects the mode and the reference code. It then clears the instance's power bits and pulses its reset bits for a timed width. After a timed settle window it releases isolation. A power-down runs the other way: isolation first, then the power bits. The first high-speed port cannot work without the device PHY, so powering it up also brings the device PHY up. Powering it down takes the device PHY down as well, unless that PHY was requested on in its own right. Timing comes from a cycles-per-microsecond parameter. One request can wait in a one-deep slot while a sequence runs.

Top module: `usbphy_pwr_seq`

## Requirements
- R1: After reset `pwr_ctl` = 15'h7FF9, which is every instance bit set and bits 1 and 2 clear. After reset `rst_ctl` = 0, `iso_en` = 3'b111, `ref_sel` = 0, `mode_host` = 0, `inst_en` = 0, `busy` = 0 and `req_ready` = 1.
- R2: Instance codes are 0 device, 1 host, 2 HSIC0 and 3 HSIC1. The power masks are device bits 0,3,4,5 (15'h0039), host bits 6..8 (15'h01C0), HSIC0 bits 9..11 (15'h0E00) and HSIC1 bits 12..14 (15'h7000). A power-up clears the instance's mask in `pwr_ctl` and a power-down sets it. No other bits change.
- R3: The reset masks in `rst_ctl` are device 11'h001, host 11'h008, HSIC0 11'h148 (bits 3,6,8) and HSIC1 11'h240 (bits 6,9). A power-up asserts the mask only after the instance's power bits are clear.
- R4: The reset mask stays high for exactly RST_US*CYC_PER_US clock cycles.
- R5: Isolation is released exactly SETTLE_US*CYC_PER_US cycles after the reset bits fall. In that same edge the instance's `inst_en` bit is set.
- R6: For device and host, `mode_host` is written (0 device, 1 host) one cycle before the power bits clear. HSIC power-ups leave `mode_host` unchanged.
- R7: A power-up loads `ref_sel` with the requested `ref_code`. Code 6 is rejected: `err` and `done` pulse together and no output or enable flag changes.
- R8: A power-down clears `inst_en` for the instance, sets its isolation, and one cycle later sets its power bits. No reset pulse is issued.
- R9: `iso_en[0]` is shared by the device and host PHYs. `iso_en[1]` belongs to HSIC0 and `iso_en[2]` to HSIC1. A bit that is 1 means isolated.
- R10: An HSIC0 power-up is followed by a full device power-up (mode 0, power, reset 11'h001, settle, `iso_en[0]` release). This companion power-up does not set the device's `inst_en` bit.
- R11: An HSIC0 power-down also powers the device PHY down (isolation, then power bits) when `inst_en[0]` is clear. When it is set, the device PHY is left on.
- R12: One request waits in a one-deep slot. `req_ready` is low while the slot is full. Queued requests run in order, and every request ends with one single-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request slot free |
| req_inst | input | 2 | Target instance (0 dev, 1 host, 2 HSIC0, 3 HSIC1) |
| req_on | input | 1 | 1 power up, 0 power down |
| ref_code | input | 3 | Reference-frequency code for a power-up |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Pulses with done when the code was rejected |
| pwr_ctl | output | 15 | Power-control image (1 = suspended/off) |
| rst_ctl | output | 11 | Reset-control image (1 = in reset) |
| iso_en | output | 3 | Isolation enables (1 = isolated) |
| ref_sel | output | 3 | Reference-frequency select |
| mode_host | output | 1 | 1 host, 0 device |
| inst_en | output | 4 | Per-instance enabled flags |

## Verification
The bench measures the reset pulse width and the settle window to the exact cycle. A counter that is off by one would show up as a width or gap one cycle too long or short. It checks the order of events: mode before power, and isolation before power on the way down. A design with the steps swapped would show a negative or zero gap. It runs both branches of the HSIC0 power-down. Skipping the device-enabled test would wrongly leave the device PHY off or on. It checks that the companion power-up leaves the device flag clear and pulses reset twice with the right masks. A queue that dropped or merged requests would give the wrong count of done pulses, and a rejected code 6 would show up as changed images.

// File: rtl/usbphy_seq_pkg.sv
// Shared types and per-instance bit maps for the USB PHY power sequencer.
// Assumes exactly four instances: device, host, HSIC0, HSIC1.
package usbphy_seq_pkg;

    localparam int NUM_INST = 4;
    localparam int PWR_W    = 15;
    localparam int RST_W    = 11;
    localparam int ISO_W    = 3;
    localparam int FSEL_W   = 3;

    localparam logic [FSEL_W-1:0] FSEL_BAD = 3'd6;

    typedef enum logic [1:0] {
        INST_DEV   = 2'd0,
        INST_HOST  = 2'd1,
        INST_HSIC0 = 2'd2,
        INST_HSIC1 = 2'd3
    } inst_e;

    typedef struct packed {
        inst_e             inst;
        logic              on;
        logic [FSEL_W-1:0] fsel;
    } req_t;

    typedef struct packed {
        logic mode;
        logic pwr_clr;
        logic rst_set;
        logic rst_clr;
        logic iso_clr;
        logic iso_set;
        logic pwr_set;
    } act_t;

    typedef enum logic [3:0] {
        S_IDLE, S_MODE, S_PWR_ON, S_RST_SET, S_RST_HOLD,
        S_SETTLE, S_ISO_SET, S_PWR_OFF, S_FIN
    } state_e;

    function automatic logic [PWR_W-1:0] pwr_mask(inst_e i);
        case (i)
            INST_DEV:   return 15'h0039;
            INST_HOST:  return 15'h01C0;
            INST_HSIC0: return 15'h0E00;
            default:    return 15'h7000;
        endcase
    endfunction

    function automatic logic [RST_W-1:0] rst_mask(inst_e i);
        case (i)
            INST_DEV:   return 11'h001;
            INST_HOST:  return 11'h008;
            INST_HSIC0: return 11'h148;
            default:    return 11'h240;
        endcase
    endfunction

    function automatic logic [1:0] iso_idx(inst_e i);
        case (i)
            INST_HSIC0: return 2'd1;
            INST_HSIC1: return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

    function automatic logic [PWR_W-1:0] pwr_all();
        logic [PWR_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_INST; k++) m |= pwr_mask(inst_e'(k));
        return m;
    endfunction

endpackage

// File: rtl/usbphy_req_slot.sv
// One-deep request holding slot. Accepts when empty; the sequencer pops it.
// Assumes pop is only raised while the slot holds a request.
module usbphy_req_slot
    import usbphy_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  req_t in_req,
    output logic in_ready,
    input  logic pop,
    output logic slot_valid,
    output req_t slot_req
);

    assign in_ready = !slot_valid;

    // Fill on accept, empty on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= 1'b0;
            slot_req   <= '0;
        end else if (in_valid && in_ready) begin
            slot_valid <= 1'b1;
            slot_req   <= in_req;
        end else if (pop) begin
            slot_valid <= 1'b0;
        end
    end

    // R12: the sequencer never takes from an empty slot
    assert_pop_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> slot_valid);

endmodule

// File: rtl/usbphy_delay_cnt.sv
// Down-counter for the reset width and settle windows.
// Assumes load values are pre-decremented by the caller (N cycles -> N-1).
module usbphy_delay_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    // Load or count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/usbphy_seq_fsm.sv
// Sequencing state machine. Pops requests, steps through mode, power,
// reset, settle and isolation stages, and runs the device companion
// sequence for HSIC0. Emits one-cycle action strobes; the register image
// module applies them. Assumes RST_CYC and SETTLE_CYC are at least 1.
module usbphy_seq_fsm
    import usbphy_seq_pkg::*;
#(
    parameter int RST_CYC    = 1250,
    parameter int SETTLE_CYC = 10000,
    parameter int CNT_W      = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_valid,
    input  req_t                slot_req,
    output logic                slot_pop,
    input  logic                tmr_zero,
    output logic                tmr_load,
    output logic [CNT_W-1:0]    tmr_val,
    output act_t                act,
    output inst_e               act_inst,
    output logic [FSEL_W-1:0]   act_fsel,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [NUM_INST-1:0] inst_en
);

    localparam logic [CNT_W-1:0] RST_LOAD    = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);

    state_e            state;
    inst_e             cur_inst;
    logic [FSEL_W-1:0] cur_fsel;
    logic              companion;
    logic              bad_code;

    assign act_inst = cur_inst;
    assign act_fsel = cur_fsel;
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_FIN);
    assign err      = (state == S_FIN) && bad_code;

    // Decode the action strobes and timer loads for the current stage.
    always_comb begin
        act      = '0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        slot_pop = 1'b0;
        case (state)
            S_IDLE:    slot_pop = slot_valid;
            S_MODE:    act.mode = 1'b1;
            S_PWR_ON:  act.pwr_clr = 1'b1;
            S_RST_SET: begin
                act.rst_set = 1'b1;
                tmr_load    = 1'b1;
                tmr_val     = RST_LOAD;
            end
            S_RST_HOLD: if (tmr_zero) begin
                act.rst_clr = 1'b1;
                tmr_load    = 1'b1;
                tmr_val     = SETTLE_LOAD;
            end
            S_SETTLE:  if (tmr_zero) act.iso_clr = 1'b1;
            S_ISO_SET: act.iso_set = 1'b1;
            S_PWR_OFF: act.pwr_set = 1'b1;
            default:   ;
        endcase
    end

    // Advance the sequence and keep the per-instance enabled flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cur_inst  <= INST_DEV;
            cur_fsel  <= '0;
            companion <= 1'b0;
            bad_code  <= 1'b0;
            inst_en   <= '0;
        end else begin
            case (state)
                S_IDLE: if (slot_valid) begin
                    cur_inst  <= slot_req.inst;
                    cur_fsel  <= slot_req.fsel;
                    companion <= 1'b0;
                    bad_code  <= 1'b0;
                    if (slot_req.on) begin
                        if (slot_req.fsel == FSEL_BAD) begin
                            bad_code <= 1'b1;
                            state    <= S_FIN;
                        end else begin
                            state <= S_MODE;
                        end
                    end else begin
                        inst_en[slot_req.inst] <= 1'b0;
                        state <= S_ISO_SET;
                    end
                end
                S_MODE:     state <= S_PWR_ON;
                S_PWR_ON:   state <= S_RST_SET;
                S_RST_SET:  state <= S_RST_HOLD;
                S_RST_HOLD: if (tmr_zero) state <= S_SETTLE;
                S_SETTLE: if (tmr_zero) begin
                    if (!companion) inst_en[cur_inst] <= 1'b1;
                    if (cur_inst == INST_HSIC0 && !companion) begin
                        cur_inst  <= INST_DEV;
                        companion <= 1'b1;
                        state     <= S_MODE;
                    end else begin
                        state <= S_FIN;
                    end
                end
                S_ISO_SET:  state <= S_PWR_OFF;
                S_PWR_OFF: begin
                    if (cur_inst == INST_HSIC0 && !companion && !inst_en[INST_DEV]) begin
                        cur_inst  <= INST_DEV;
                        companion <= 1'b1;
                        state     <= S_ISO_SET;
                    end else begin
                        state <= S_FIN;
                    end
                end
                S_FIN:      state <= S_IDLE;
                default:    state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/usbphy_reg_image.sv
// Register images driven to the PHY macro: power, reset, isolation,
// reference select and mode. Applies the sequencer's action strobes for
// the addressed instance. Assumes at most one strobe per cycle.
module usbphy_reg_image
    import usbphy_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  act_t              act,
    input  inst_e             act_inst,
    input  logic [FSEL_W-1:0] act_fsel,
    output logic [PWR_W-1:0]  pwr_ctl,
    output logic [RST_W-1:0]  rst_ctl,
    output logic [ISO_W-1:0]  iso_en,
    output logic [FSEL_W-1:0] ref_sel,
    output logic              mode_host
);

    localparam logic [PWR_W-1:0] PWR_RESET = pwr_all();

    // Power image: clear on power-up, set on power-down.
    always_ff @(posedge clk) begin
        if (!rst_n)            pwr_ctl <= PWR_RESET;
        else if (act.pwr_clr)  pwr_ctl <= pwr_ctl & ~pwr_mask(act_inst);
        else if (act.pwr_set)  pwr_ctl <= pwr_ctl | pwr_mask(act_inst);
    end

    // Reset image: assert and release the instance's reset mask.
    always_ff @(posedge clk) begin
        if (!rst_n)            rst_ctl <= '0;
        else if (act.rst_set)  rst_ctl <= rst_ctl | rst_mask(act_inst);
        else if (act.rst_clr)  rst_ctl <= rst_ctl & ~rst_mask(act_inst);
    end

    // Reference select and mode bit, written in the mode stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_sel   <= '0;
            mode_host <= 1'b0;
        end else if (act.mode) begin
            ref_sel <= act_fsel;
            if (act_inst == INST_DEV || act_inst == INST_HOST)
                mode_host <= (act_inst == INST_HOST);
        end
    end

    // One isolation bit per domain; device and host map to domain 0.
    for (genvar k = 0; k < ISO_W; k++) begin : g_iso
        localparam logic [1:0] IDX = 2'(k);
        logic hit;
        assign hit = (iso_idx(act_inst) == IDX);
        // Set or release this domain's isolation.
        always_ff @(posedge clk) begin
            if (!rst_n)                   iso_en[k] <= 1'b1;
            else if (act.iso_set && hit)  iso_en[k] <= 1'b1;
            else if (act.iso_clr && hit)  iso_en[k] <= 1'b0;
        end
    end

endmodule

// File: rtl/usbphy_pwr_seq.sv
// Top of the USB PHY power sequencer: request slot, sequencing FSM,
// delay counter and register images. Delays derive from CYC_PER_US.
// Assumes a single clock and synchronous active-low reset.
module usbphy_pwr_seq
    import usbphy_seq_pkg::*;
#(
    parameter int CYC_PER_US = 125,
    parameter int RST_US     = 10,
    parameter int SETTLE_US  = 80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_inst,
    input  logic        req_on,
    input  logic [2:0]  ref_code,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [14:0] pwr_ctl,
    output logic [10:0] rst_ctl,
    output logic [2:0]  iso_en,
    output logic [2:0]  ref_sel,
    output logic        mode_host,
    output logic [3:0]  inst_en
);

    localparam int RST_CYC    = RST_US * CYC_PER_US;
    localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int MAX_CYC    = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    req_t              in_req, slot_req;
    logic              slot_valid, slot_pop;
    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;
    act_t              act;
    inst_e             act_inst;
    logic [FSEL_W-1:0] act_fsel;

    assign in_req = {inst_e'(req_inst), req_on, ref_code};

    usbphy_req_slot u_slot (
        .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_req(in_req),
        .in_ready(req_ready), .pop(slot_pop), .slot_valid(slot_valid),
        .slot_req(slot_req)
    );

    usbphy_delay_cnt #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .zero(tmr_zero)
    );

    usbphy_seq_fsm #(.RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_req(slot_req),
        .slot_pop(slot_pop), .tmr_zero(tmr_zero), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .act(act), .act_inst(act_inst), .act_fsel(act_fsel),
        .busy(busy), .done(done), .err(err), .inst_en(inst_en)
    );

    usbphy_reg_image u_img (
        .clk(clk), .rst_n(rst_n), .act(act), .act_inst(act_inst),
        .act_fsel(act_fsel), .pwr_ctl(pwr_ctl), .rst_ctl(rst_ctl),
        .iso_en(iso_en), .ref_sel(ref_sel), .mode_host(mode_host)
    );

    // Checker support: cycles the reset image has been non-zero.
    localparam int HI_W = $clog2(RST_CYC + 2);
    logic [HI_W-1:0] rst_hi_cnt;
    // Count reset-high cycles, clear when reset image is zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               rst_hi_cnt <= '0;
        else if (rst_ctl != '0)   rst_hi_cnt <= rst_hi_cnt + 1'b1;
        else                      rst_hi_cnt <= '0;
    end

    // R3: reset asserted only while the instance's power bits are clear
    assert_rst_after_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_ctl != '0) |-> ((pwr_ctl & pwr_mask(act_inst)) == '0));

    // R4: reset pulse width in cycles
    assert_rst_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_ctl) != '0 && rst_ctl == '0) |-> (rst_hi_cnt == HI_W'(RST_CYC)));

    // R5: isolation is released only after reset has been removed
    assert_iso_release_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(iso_en)) & ~iso_en) != '0) |-> (rst_ctl == '0));

    // R8: power bits rise only while their isolation domain is isolated
    assert_otg_iso_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_ctl & ~$past(pwr_ctl) & 15'h01F9) != '0) |-> iso_en[0]);
    assert_hsic0_iso_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_ctl & ~$past(pwr_ctl) & 15'h0E00) != '0) |-> iso_en[1]);
    assert_hsic1_iso_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_ctl & ~$past(pwr_ctl) & 15'h7000) != '0) |-> iso_en[2]);

    // R12: images hold while no sequence is running
    assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> ($stable(pwr_ctl) && $stable(rst_ctl) && $stable(iso_en)));

    // R7: a rejected request leaves the images untouched
    assert_reject_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(pwr_ctl) && $stable(iso_en) && $stable(ref_sel)));

endmodule

// File: tb/usbphy_pwr_seq_tb.sv
// Self-checking bench: vector table walk, then directed timing,
// ordering, companion and queue tests.
module usbphy_pwr_seq_tb;

    localparam int CPU        = 4;
    localparam int RST_CYC    = 10 * CPU;
    localparam int SETTLE_CYC = 80 * CPU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_inst = '0;
    logic        req_on = 1'b0;
    logic [2:0]  ref_code = '0;
    logic        busy, done, err, mode_host;
    logic [14:0] pwr_ctl;
    logic [10:0] rst_ctl;
    logic [2:0]  iso_en, ref_sel;
    logic [3:0]  inst_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    usbphy_pwr_seq #(.CYC_PER_US(CPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_inst(req_inst), .req_on(req_on), .ref_code(ref_code),
        .busy(busy), .done(done), .err(err), .pwr_ctl(pwr_ctl),
        .rst_ctl(rst_ctl), .iso_en(iso_en), .ref_sel(ref_sel),
        .mode_host(mode_host), .inst_en(inst_en)
    );

    // {inst, on, code, pwr, iso, mode, ref, en, err}
    localparam logic [32:0] VEC [12] = '{
        {2'd0, 1'b1, 3'd5, 15'h7FC0, 3'b110, 1'b0, 3'd5, 4'b0001, 1'b0}, // R2 R9 dev on
        {2'd1, 1'b1, 3'd2, 15'h7E00, 3'b110, 1'b1, 3'd2, 4'b0011, 1'b0}, // R6 host on
        {2'd1, 1'b0, 3'd2, 15'h7FC0, 3'b111, 1'b1, 3'd2, 4'b0001, 1'b0}, // R9 shared iso
        {2'd3, 1'b1, 3'd6, 15'h7FC0, 3'b111, 1'b1, 3'd2, 4'b0001, 1'b1}, // R7 bad code
        {2'd3, 1'b1, 3'd7, 15'h0FC0, 3'b011, 1'b1, 3'd7, 4'b1001, 1'b0}, // R7 hsic1 on
        {2'd0, 1'b0, 3'd0, 15'h0FF9, 3'b011, 1'b1, 3'd7, 4'b1000, 1'b0}, // R8 dev off
        {2'd2, 1'b1, 3'd0, 15'h01C0, 3'b000, 1'b0, 3'd0, 4'b1100, 1'b0}, // R10 companion
        {2'd2, 1'b0, 3'd0, 15'h0FF9, 3'b011, 1'b0, 3'd0, 4'b1000, 1'b0}, // R11 dev off too
        {2'd0, 1'b1, 3'd1, 15'h0FC0, 3'b010, 1'b0, 3'd1, 4'b1001, 1'b0}, // R2 dev on
        {2'd2, 1'b1, 3'd4, 15'h01C0, 3'b000, 1'b0, 3'd4, 4'b1101, 1'b0}, // R10 hsic0 on
        {2'd2, 1'b0, 3'd4, 15'h0FC0, 3'b010, 1'b0, 3'd4, 4'b1001, 1'b0}, // R11 dev kept
        {2'd3, 1'b0, 3'd4, 15'h7FC0, 3'b110, 1'b0, 3'd4, 4'b0001, 1'b0}  // R8 hsic1 off
    };

    // Event monitor, sampled on the falling edge.
    int cyc = 0;
    int t_mode, t_pwr, t_rst_rise, t_rst_fall, rst_pulses, done_cnt;
    int t_iso_fall [3];
    int t_iso_rise [3];
    logic [10:0] first_rst, last_rst, p_rst;
    logic [14:0] p_pwr;
    logic [2:0]  p_iso;
    logic        p_mode;

    task automatic clear_mon();
        t_mode = -1; t_pwr = -1; t_rst_rise = -1; t_rst_fall = -1;
        rst_pulses = 0; done_cnt = 0; first_rst = '0; last_rst = '0;
        for (int k = 0; k < 3; k++) begin t_iso_fall[k] = -1; t_iso_rise[k] = -1; end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mode_host != p_mode) t_mode = cyc;
            if (pwr_ctl != p_pwr) t_pwr = cyc;
            if (p_rst == '0 && rst_ctl != '0) begin
                t_rst_rise = cyc;
                if (rst_pulses == 0) first_rst = rst_ctl;
                last_rst = rst_ctl;
                rst_pulses++;
            end
            if (p_rst != '0 && rst_ctl == '0) t_rst_fall = cyc;
            for (int k = 0; k < 3; k++) begin
                if (p_iso[k] && !iso_en[k]) t_iso_fall[k] = cyc;
                if (!p_iso[k] && iso_en[k]) t_iso_rise[k] = cyc;
            end
            if (done) done_cnt++;
        end
        p_mode = mode_host; p_pwr = pwr_ctl; p_rst = rst_ctl; p_iso = iso_en;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] i, input logic o, input logic [2:0] c);
        @(negedge clk);
        req_valid = 1'b1; req_inst = i; req_on = o; ref_code = c;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_req(input logic [1:0] i, input logic o, input logic [2:0] c,
                          output logic e);
        send(i, o, c);
        while (!done) @(negedge clk);
        e = err;
        @(negedge clk);
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic e;
        clear_mon();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pwr_ctl", 32'(pwr_ctl), 32'h7FF9);
        check("R1 rst_ctl", 32'(rst_ctl), 0);
        check("R1 iso_en", 32'(iso_en), 32'h7);
        check("R1 ref_sel", 32'(ref_sel), 0);
        check("R1 mode", 32'(mode_host), 0);
        check("R1 inst_en", 32'(inst_en), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 ready", 32'(req_ready), 1);

        // Table walk
        for (int n = 0; n < 12; n++) begin
            do_req(VEC[n][32:31], VEC[n][30], VEC[n][29:27], e);
            check($sformatf("R2 pwr step %0d", n), 32'(pwr_ctl), 32'(VEC[n][26:12]));
            check($sformatf("R9 iso step %0d", n), 32'(iso_en), 32'(VEC[n][11:9]));
            check($sformatf("R6 mode step %0d", n), 32'(mode_host), 32'(VEC[n][8]));
            check($sformatf("R7 ref step %0d", n), 32'(ref_sel), 32'(VEC[n][7:5]));
            check($sformatf("R11 en step %0d", n), 32'(inst_en), 32'(VEC[n][4:1]));
            check($sformatf("R7 err step %0d", n), 32'(e), 32'(VEC[n][0]));
            check($sformatf("R3 rst idle step %0d", n), 32'(rst_ctl), 0);
            check($sformatf("R12 busy step %0d", n), 32'(busy), 0);
        end

        // Host power-up: mode one cycle before power, reset mask 0x008
        clear_mon();
        do_req(2'd1, 1'b1, 3'd5, e);
        check("R6 mode before pwr", 32'(t_pwr - t_mode), 1);
        check("R6 host mode", 32'(mode_host), 1);
        check("R3 host rst mask", 32'(first_rst), 32'h008);

        // HSIC1 power-up: reset width, settle window, mode untouched
        clear_mon();
        do_req(2'd3, 1'b1, 3'd3, e);
        check("R3 hsic1 rst mask", 32'(first_rst), 32'h240);
        check("R4 reset width", 32'(t_rst_fall - t_rst_rise), RST_CYC);
        check("R5 settle window", 32'(t_iso_fall[2] - t_rst_fall), SETTLE_CYC);
        check("R5 hsic1 enabled", 32'(inst_en[3]), 1);
        check("R6 hsic leaves mode", 32'(mode_host), 1);
        check("R7 ref loaded", 32'(ref_sel), 3);

        // HSIC1 power-down: isolation one cycle before power, no reset
        clear_mon();
        do_req(2'd3, 1'b0, 3'd0, e);
        check("R8 iso before pwr", 32'(t_pwr - t_iso_rise[2]), 1);
        check("R8 no reset pulse", 32'(rst_pulses), 0);
        check("R8 hsic1 disabled", 32'(inst_en[3]), 0);
        check("R8 hsic1 pwr set", 32'(pwr_ctl & 15'h7000), 32'h7000);

        // Queue: device off, then HSIC0 on waiting in the slot
        clear_mon();
        send(2'd0, 1'b0, 3'd0);
        req_valid = 1'b1; req_inst = 2'd2; req_on = 1'b1; ref_code = 3'd2;
        check("R12 ready low when full", 32'(req_ready), 0);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 ready low while queued", 32'(req_ready), 0);
        check("R12 busy while queued", 32'(busy), 1);
        while (done_cnt < 2) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R12 two done pulses", 32'(done_cnt), 2);
        check("R10 two reset pulses", 32'(rst_pulses), 2);
        check("R10 hsic0 rst mask", 32'(first_rst), 32'h148);
        check("R10 device rst mask", 32'(last_rst), 32'h001);
        check("R10 device mode", 32'(mode_host), 0);
        check("R10 device powered", 32'(pwr_ctl & 15'h0039), 0);
        check("R10 device flag clear", 32'(inst_en), 32'b0110);
        check("R10 iso", 32'(iso_en), 32'b100);
        check("R12 idle after", 32'(busy), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule